// File: doc/BRIEF.md
# Three-Phase DC Commutation Output Mask

This block sits at the output stage of a three-channel motor PWM unit and drives six bridge outputs: one high-side (A) and one low-side (B) output per channel. In normal operation each output copies the matching per-channel A or B waveform. When DC commutation is enabled, the block ignores every per-channel waveform except the A waveform of one reference channel, channel 0 by default. It routes that single waveform to whichever of the six outputs a 6-bit commutation pattern selects.

Outputs that the pattern does not select sit at a passive level set by a polarity input. An invert input flips the three low-side outputs after masking, for gate drivers whose low-side inputs are active-low.

The commutation pattern is double-buffered. Software writes a shadow copy. The active copy, which gates the outputs and is the value read back, takes the shadow value only when the PWM-cycle-start strobe arrives. Commutation steps therefore always begin on a PWM cycle boundary. All outputs are registered.

Top module: `cmx_dc_commutator`

## Requirements
- R1: While `rst_n` is low, all six outputs, the shadow pattern and the active pattern are 0.
- R2: A write (`pat_wr` high) stores `pat_wdata` in the shadow pattern only. `pat_rdata` and the outputs do not react to it until a cycle-start strobe.
- R3: At a clock edge where `cyc_start` is high, the active pattern takes the shadow value held before that edge. If a write lands in the same cycle, the old shadow value is loaded and the new value waits for the next strobe. `pat_rdata` shows the active pattern.
- R4: With `dc_en` low, `a_out[i]` and `b_out[i]` equal `a_in[i]` and `b_in[i]` from the previous clock. The pattern, `pol` and `inv_b` have no effect.
- R5: With `dc_en` high, pattern bit 2i gates `a_out[i]` and bit 2i+1 gates `b_out[i]` (bit 0 = A0, 1 = B0, 2 = A1, 3 = B1, 4 = A2, 5 = B2). A gated output follows `a_in[0]` from the previous clock. `a_in[2:1]` and `b_in` have no effect.
- R6: With `dc_en` high, an output whose pattern bit is 0 drives the passive level. The passive level equals `pol`: 0 gives low, 1 gives high.
- R7: With `dc_en` high and `inv_b` high, each B output is inverted after masking, so a masked B output drives the inverse of `pol`. A outputs are never inverted.
- R8: Outputs are registered. A change of the active pattern reaches the outputs at the first clock edge after the edge that loaded it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_en | input | 1 | DC commutation enable |
| pol | input | 1 | Passive level of masked outputs |
| inv_b | input | 1 | Invert the B outputs in DC mode |
| cyc_start | input | 1 | PWM-cycle-start strobe; loads the active pattern |
| pat_wr | input | 1 | Write strobe for the shadow pattern |
| pat_wdata | input | 6 | Pattern value to write |
| pat_rdata | output | 6 | Active pattern |
| a_in | input | 3 | Per-channel A waveforms |
| b_in | input | 3 | Per-channel B waveforms |
| a_out | output | 3 | High-side bridge outputs |
| b_out | output | 3 | Low-side bridge outputs |

## Verification
The bench sweeps every pattern value against every combination of mode, polarity, invert and input waveform. This catches a swapped A/B bit mapping, which would move the reference waveform to the wrong output. It also catches inversion applied before the mask, which would leave masked B outputs at `pol` instead of its inverse, and a B output driven as the complement of A. It drives unused channel inputs so that a design leaking them into DC mode shows wrong levels.

The pattern tests write without a strobe and write in the same cycle as a strobe. A design that loaded the active copy on the write, or took the new write at a colliding strobe, would show the wrong `pat_rdata` or switch commutation mid-cycle.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

   typedef struct packed {
      logic dc_en;
      logic pol;
      logic inv_b;
   } cmx_ctrl_t;

   // pattern bit that gates lane (ch, is_b)
   function automatic int unsigned cmx_lane_bit(input int unsigned ch, input bit is_b);
      return 2 * ch + (is_b ? 1 : 0);
   endfunction

endpackage

// File: rtl/cmx_pattern_shadow.sv
module cmx_pattern_shadow #(
   parameter int unsigned       W         = 6,
   parameter logic [W-1:0]      RST_VALUE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         load,
   output logic [W-1:0] shadow_q,
   output logic [W-1:0] active_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST_VALUE;
      end else if (wr_en) begin
         shadow_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= RST_VALUE;
      end else if (load) begin
         active_q <= shadow_q;
      end
   end

endmodule

// File: rtl/cmx_out_lane.sv
module cmx_out_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic dc_en,
   input  logic gate,
   input  logic ref_wave,
   input  logic direct,
   input  logic passive,
   input  logic inv_en,
   output logic out_q
);

   logic masked;
   logic dc_val;
   logic nxt;

   always_comb begin
      masked = gate ? ref_wave : passive;
      dc_val = masked ^ inv_en;
      nxt    = dc_en ? dc_val : direct;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else begin
         out_q <= nxt;
      end
   end

endmodule

// File: rtl/cmx_dc_commutator.sv
module cmx_dc_commutator #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned REF_CH = 0,
   localparam int unsigned PW    = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dc_en,
   input  logic              pol,
   input  logic              inv_b,
   input  logic              cyc_start,
   input  logic              pat_wr,
   input  logic [PW-1:0]     pat_wdata,
   output logic [PW-1:0]     pat_rdata,
   input  logic [NUM_CH-1:0] a_in,
   input  logic [NUM_CH-1:0] b_in,
   output logic [NUM_CH-1:0] a_out,
   output logic [NUM_CH-1:0] b_out
);
   import cmx_pkg::*;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("cmx_dc_commutator: NUM_CH must be 1..8");
   end
   if (REF_CH >= NUM_CH) begin : g_bad_ref
      $error("cmx_dc_commutator: REF_CH must be below NUM_CH");
   end

   cmx_ctrl_t     ctrl;
   logic [PW-1:0] shadow_pat;
   logic [PW-1:0] active_pat;
   logic          ref_wave;

   assign ctrl     = '{dc_en: dc_en, pol: pol, inv_b: inv_b};
   assign ref_wave = a_in[REF_CH];

   cmx_pattern_shadow #(.W(PW)) u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (pat_wr),
      .wr_data  (pat_wdata),
      .load     (cyc_start),
      .shadow_q (shadow_pat),
      .active_q (active_pat)
   );

   assign pat_rdata = active_pat;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      for (genvar s = 0; s < 2; s++) begin : g_side
         localparam int unsigned BIT = cmx_lane_bit(ch, s == 1);
         logic lane_q;
         if (s == 0) begin : g_a
            cmx_out_lane u_lane (
               .clk      (clk),
               .rst_n    (rst_n),
               .dc_en    (ctrl.dc_en),
               .gate     (active_pat[BIT]),
               .ref_wave (ref_wave),
               .direct   (a_in[ch]),
               .passive  (ctrl.pol),
               .inv_en   (1'b0),
               .out_q    (lane_q)
            );
            assign a_out[ch] = lane_q;
         end else begin : g_b
            cmx_out_lane u_lane (
               .clk      (clk),
               .rst_n    (rst_n),
               .dc_en    (ctrl.dc_en),
               .gate     (active_pat[BIT]),
               .ref_wave (ref_wave),
               .direct   (b_in[ch]),
               .passive  (ctrl.pol),
               .inv_en   (ctrl.inv_b),
               .out_q    (lane_q)
            );
            assign b_out[ch] = lane_q;
         end
      end
   end

endmodule

// File: rtl/cmx_dc_commutator_chk.sv
module cmx_dc_commutator_chk #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned REF_CH = 0,
   localparam int unsigned PW    = 2 * NUM_CH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dc_en,
   input logic              pol,
   input logic              inv_b,
   input logic              cyc_start,
   input logic              pat_wr,
   input logic [PW-1:0]     pat_wdata,
   input logic [PW-1:0]     pat_rdata,
   input logic [PW-1:0]     shadow_pat,
   input logic [NUM_CH-1:0] a_in,
   input logic [NUM_CH-1:0] b_in,
   input logic [NUM_CH-1:0] a_out,
   input logic [NUM_CH-1:0] b_out
);

   always_comb begin
      if (!rst_n) begin
         a_r1_reset_clear : assert (a_out == '0 && b_out == '0 && pat_rdata == '0);
      end
   end

   a_r2_write_shadow_only : assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(pat_rdata));

   a_r2_shadow_takes_write : assert property (@(posedge clk) disable iff (!rst_n)
      pat_wr |=> shadow_pat == $past(pat_wdata));

   a_r3_load_on_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> pat_rdata == $past(shadow_pat));

   a_r4_direct_mode : assert property (@(posedge clk) disable iff (!rst_n)
      !dc_en |=> (a_out == $past(a_in)) && (b_out == $past(b_in)));

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      a_r5_a_follows_ref : assert property (@(posedge clk) disable iff (!rst_n)
         (dc_en && pat_rdata[2*ch]) |=> a_out[ch] == $past(a_in[REF_CH]));
      a_r6_a_passive : assert property (@(posedge clk) disable iff (!rst_n)
         (dc_en && !pat_rdata[2*ch]) |=> a_out[ch] == $past(pol));
      a_r7_b_masked_inv : assert property (@(posedge clk) disable iff (!rst_n)
         (dc_en && !pat_rdata[2*ch+1]) |=> b_out[ch] == ($past(pol) ^ $past(inv_b)));
      a_r7_b_gated_inv : assert property (@(posedge clk) disable iff (!rst_n)
         (dc_en && pat_rdata[2*ch+1]) |=> b_out[ch] == ($past(a_in[REF_CH]) ^ $past(inv_b)));
   end

endmodule

bind cmx_dc_commutator cmx_dc_commutator_chk #(.NUM_CH(NUM_CH), .REF_CH(REF_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dc_en      (dc_en),
   .pol        (pol),
   .inv_b      (inv_b),
   .cyc_start  (cyc_start),
   .pat_wr     (pat_wr),
   .pat_wdata  (pat_wdata),
   .pat_rdata  (pat_rdata),
   .shadow_pat (shadow_pat),
   .a_in       (a_in),
   .b_in       (b_in),
   .a_out      (a_out),
   .b_out      (b_out)
);

// File: tb/sim_cmx_dc_commutator.sv
`timescale 1ns/1ps
module sim_cmx_dc_commutator;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dc_en = 1'b0, pol = 1'b0, inv_b = 1'b0, cyc_start = 1'b0, pat_wr = 1'b0;
   logic [5:0] pat_wdata = '0;
   logic [5:0] pat_rdata;
   logic [2:0] a_in = '0, b_in = '0, a_out, b_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cmx_dc_commutator u0 (
      .clk(clk), .rst_n(rst_n), .dc_en(dc_en), .pol(pol), .inv_b(inv_b),
      .cyc_start(cyc_start), .pat_wr(pat_wr), .pat_wdata(pat_wdata),
      .pat_rdata(pat_rdata), .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // expected {b_out, a_out} from the requirements
   function automatic logic [5:0] model(input logic dc, input logic p, input logic iv,
                                        input logic [5:0] pat, input logic [2:0] a,
                                        input logic [2:0] b);
      logic [2:0] ea, eb;
      for (int i = 0; i < 3; i++) begin
         if (!dc) begin
            ea[i] = a[i];
            eb[i] = b[i];
         end else begin
            ea[i] = pat[2*i]   ? a[0] : p;
            eb[i] = (pat[2*i+1] ? a[0] : p) ^ iv;
         end
      end
      return {eb, ea};
   endfunction

   task automatic load_pattern(input logic [5:0] v);
      pat_wr = 1'b1; pat_wdata = v;
      step();
      pat_wr = 1'b0; cyc_start = 1'b1;
      step();
      cyc_start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] e;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(a_out == 0 && b_out == 0, "R1 outputs", {b_out, a_out}, 0);
      check(pat_rdata == 0, "R1 pattern", pat_rdata, 0);
      rst_n = 1'b1;
      step();

      // R2: write without strobe changes neither readback nor outputs
      dc_en = 1'b1; pol = 1'b0; a_in = 3'b001;
      pat_wr = 1'b1; pat_wdata = 6'h2D;
      step();
      pat_wr = 1'b0;
      check(pat_rdata == 0, "R2 readback", pat_rdata, 0);
      step();
      check({b_out, a_out} == 6'h00, "R2 outputs", {b_out, a_out}, 0);

      // R3: strobe colliding with write loads old shadow
      cyc_start = 1'b1; pat_wr = 1'b1; pat_wdata = 6'h12;
      step();
      cyc_start = 1'b0; pat_wr = 1'b0;
      check(pat_rdata == 6'h2D, "R3 collide", pat_rdata, 6'h2D);
      // R8: pattern reaches outputs one edge after the load edge
      step();
      e = model(1, 0, 0, 6'h2D, 3'b001, 3'b000);
      check({b_out, a_out} == e, "R8 latency", {b_out, a_out}, e);
      cyc_start = 1'b1;
      step();
      cyc_start = 1'b0;
      check(pat_rdata == 6'h12, "R3 next strobe", pat_rdata, 6'h12);

      // R4..R7 exhaustive sweep
      for (int p = 0; p < 64; p++) begin
         load_pattern(p[5:0]);
         check(pat_rdata == p[5:0], "R3 load", pat_rdata, p);
         for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 8; a++) begin
               for (int b = 0; b < 8; b++) begin
                  dc_en = m[0]; pol = m[1]; inv_b = m[2];
                  a_in = a[2:0]; b_in = b[2:0];
                  step();
                  e = model(m[0], m[1], m[2], p[5:0], a[2:0], b[2:0]);
                  if (!m[0])
                     check({b_out, a_out} == e, "R4 direct", {b_out, a_out}, e);
                  else if (m[2])
                     check({b_out, a_out} == e, "R7 inverted B", {b_out, a_out}, e);
                  else if (m[1])
                     check({b_out, a_out} == e, "R6 passive high", {b_out, a_out}, e);
                  else
                     check({b_out, a_out} == e, "R5 gating", {b_out, a_out}, e);
               end
            end
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule